// File: doc/BRIEF.md
# Credit-Based Egress Shaper

This block decides, on one egress port, whether the next frame should come from a reserved-bandwidth queue or from a best-effort queue. It keeps a signed credit value. The credit drains at a programmed send rate while a reserved frame is on the wire. It refills at a programmed idle rate while reserved traffic is waiting and cannot go. Reserved frames are therefore gated by the sign of the credit, not by strict priority. Best-effort frames fill the gaps that a drained credit leaves. After a best-effort frame has held back reserved traffic, the refilled credit lets reserved frames go out back to back.

The surrounding logic supplies queue-nonempty flags and the length of the head frame of each queue, measured in byte-time ticks. It also supplies the two slopes and the upper and lower credit limits. The block answers with a one-cycle grant that names the chosen queue and with a busy flag. The busy flag covers the frame's duration. A frame in flight is never interrupted. The configuration is expected to satisfy lower limit <= 0 <= upper limit.

Top module: `cbs_shaper`

## Requirements
- R1: While the link is idle, a pending reserved frame is granted (grant_rsv high) when the credit is zero or positive, and in that case it wins over a pending best-effort frame.
- R2: On each tick while a reserved frame is on the wire, the credit drops by send_slope and may become negative.
- R3: While the link is idle and the credit is negative, a pending best-effort frame is granted and the reserved queue is not.
- R4: On each tick while the reserved queue is pending but not transmitting (idle and blocked, or waiting behind a best-effort frame), the credit rises by idle_slope.
- R5: On a tick with the reserved queue empty, not transmitting, and a positive credit, the credit becomes zero.
- R6: On a tick with the reserved queue empty, not transmitting, and a negative credit, the credit rises by idle_slope and never goes above zero.
- R7: After every tick the credit lies within [lo_credit, hi_credit].
- R8: No grant is issued while link_busy is high, whatever the pending flags are.
- R9: The credit and the frame-length count change only on cycles with byte_tick high. The cycle that grants a reserved frame leaves the credit unchanged.
- R10: A grant is high for one cycle. link_busy rises in the next cycle and stays high for exactly the granted frame length in ticks, where a length of 0 counts as 1.
- R11: After reset the credit is 0 and link_busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_tick | input | 1 | One-cycle strobe per byte time on the wire |
| rsv_pending | input | 1 | Reserved queue holds at least one frame |
| be_pending | input | 1 | Best-effort queue holds at least one frame |
| rsv_len | input | LEN_W (12) | Head reserved frame length in ticks |
| be_len | input | LEN_W (12) | Head best-effort frame length in ticks |
| idle_slope | input | SLOPE_W (16) | Credit gain per tick while reserved traffic waits |
| send_slope | input | SLOPE_W (16) | Credit loss per tick while reserved traffic sends |
| hi_credit | input | CREDIT_W (32) | Signed upper credit limit |
| lo_credit | input | CREDIT_W (32) | Signed lower credit limit |
| grant_rsv | output | 1 | Pulse: reserved queue may start its frame |
| grant_be | output | 1 | Pulse: best-effort queue may start its frame |
| link_busy | output | 1 | A granted frame occupies the link |
| credit_o | output | CREDIT_W (32) | Current signed credit |

## Verification
A wrong credit value can be seen on credit_o at the first tick after the fault. It also shows up in the grants: a sign error moves the next decision between the two queues at the first idle cycle after the frame in flight ends. A wrong frame-length count can be seen in link_busy, which rises or falls one or more ticks too early or too late. A follow-on grant then appears at the wrong time or appears while the link is still busy. The directed cases cover each of these. Every credit step is compared at every tick, and each grant is checked in the exact cycle it is due.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_RSV  = 2'd1,
    OWN_BE   = 2'd2
  } owner_e;
endpackage

// File: rtl/cbs_arbiter.sv
module cbs_arbiter
  import cbs_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_tick,
  input  logic             rsv_pending,
  input  logic             be_pending,
  input  logic             credit_neg,
  input  logic [LEN_W-1:0] rsv_len,
  input  logic [LEN_W-1:0] be_len,
  output logic             grant_rsv,
  output logic             grant_be,
  output logic             busy,
  output logic             rsv_on_wire
);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  logic [LEN_W-1:0] cnt_q, cnt_d;
  owner_e           own_q, own_d;
  logic             cnt_en;

  assign busy        = (cnt_q != '0);
  assign rsv_on_wire = busy && (own_q == OWN_RSV);

  // Decisions are taken only on an idle link; reserved needs a non-negative credit.
  assign grant_rsv = !busy && rsv_pending && !credit_neg;
  assign grant_be  = !busy && be_pending && !grant_rsv;

  always_comb begin
    cnt_d  = cnt_q;
    own_d  = own_q;
    cnt_en = 1'b0;
    if (grant_rsv) begin
      cnt_en = 1'b1;
      cnt_d  = (rsv_len == '0) ? LEN_ONE : rsv_len;
      own_d  = OWN_RSV;
    end else if (grant_be) begin
      cnt_en = 1'b1;
      cnt_d  = (be_len == '0) ? LEN_ONE : be_len;
      own_d  = OWN_BE;
    end else if (busy && byte_tick) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - LEN_ONE;
      own_d  = (cnt_q == LEN_ONE) ? OWN_NONE : own_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      own_q <= OWN_NONE;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      own_q <= own_d;
    end
  end

  // R9: the length count holds between ticks while a frame is on the wire
  p_len_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !byte_tick) |=> (cnt_q == $past(cnt_q)));

  // R10: a frame of length one ends after its single tick
  p_one_tick_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && byte_tick && cnt_q == LEN_ONE) |=> !busy);
endmodule

// File: rtl/cbs_credit.sv
module cbs_credit #(
  parameter int CREDIT_W = 32,
  parameter int SLOPE_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       byte_tick,
  input  logic                       rsv_pending,
  input  logic                       rsv_grant,
  input  logic                       rsv_sending,
  input  logic [SLOPE_W-1:0]         idle_slope,
  input  logic [SLOPE_W-1:0]         send_slope,
  input  logic signed [CREDIT_W-1:0] hi_credit,
  input  logic signed [CREDIT_W-1:0] lo_credit,
  output logic signed [CREDIT_W-1:0] credit
);
  localparam int WW = CREDIT_W + 1;
  localparam int PAD = WW - SLOPE_W;

  logic signed [CREDIT_W-1:0] cr_q, cr_d;
  logic signed [WW-1:0]       cur_w, up_w, dn_w, raw_w, hi_w, lo_w, clip_w;
  logic                       cr_en;

  assign cur_w = WW'(cr_q);
  assign hi_w  = WW'(hi_credit);
  assign lo_w  = WW'(lo_credit);
  assign up_w  = cur_w + $signed({{PAD{1'b0}}, idle_slope});
  assign dn_w  = cur_w - $signed({{PAD{1'b0}}, send_slope});

  always_comb begin
    if (rsv_sending)      raw_w = dn_w;
    else if (rsv_pending) raw_w = up_w;
    else if (cr_q > 0)    raw_w = '0;
    else if (cr_q < 0)    raw_w = (up_w > 0) ? WW'(0) : up_w;
    else                  raw_w = '0;

    if (raw_w > hi_w)      clip_w = hi_w;
    else if (raw_w < lo_w) clip_w = lo_w;
    else                   clip_w = raw_w;

    cr_en = byte_tick && !rsv_grant;
    cr_d  = clip_w[CREDIT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cr_q <= '0;
    else if (cr_en) cr_q <= cr_d;
  end

  assign credit = cr_q;

  // R9: no movement without a tick
  p_no_tick_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_tick |=> $stable(credit));

  // R7: bounds respected after every tick
  p_bounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_tick && $past(1'b1) && lo_credit <= 0 && hi_credit >= 0) |=>
      (credit <= $past(hi_credit) && credit >= $past(lo_credit)));

  // R5/R6: an empty reserved queue never leaves the credit above zero
  p_empty_not_positive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_tick && !rsv_pending && !rsv_sending && lo_credit <= 0) |=> (credit <= 0));
endmodule

// File: rtl/cbs_shaper.sv
module cbs_shaper #(
  parameter int CREDIT_W = 32,
  parameter int SLOPE_W  = 16,
  parameter int LEN_W    = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       byte_tick,
  input  logic                       rsv_pending,
  input  logic                       be_pending,
  input  logic [LEN_W-1:0]           rsv_len,
  input  logic [LEN_W-1:0]           be_len,
  input  logic [SLOPE_W-1:0]         idle_slope,
  input  logic [SLOPE_W-1:0]         send_slope,
  input  logic signed [CREDIT_W-1:0] hi_credit,
  input  logic signed [CREDIT_W-1:0] lo_credit,
  output logic                       grant_rsv,
  output logic                       grant_be,
  output logic                       link_busy,
  output logic signed [CREDIT_W-1:0] credit_o
);
  logic rsv_on_wire;
  logic signed [CREDIT_W-1:0] credit_w;

  cbs_arbiter #(.LEN_W(LEN_W)) arb_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_tick   (byte_tick),
    .rsv_pending (rsv_pending),
    .be_pending  (be_pending),
    .credit_neg  (credit_w[CREDIT_W-1]),
    .rsv_len     (rsv_len),
    .be_len      (be_len),
    .grant_rsv   (grant_rsv),
    .grant_be    (grant_be),
    .busy        (link_busy),
    .rsv_on_wire (rsv_on_wire)
  );

  cbs_credit #(.CREDIT_W(CREDIT_W), .SLOPE_W(SLOPE_W)) crd_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_tick   (byte_tick),
    .rsv_pending (rsv_pending),
    .rsv_grant   (grant_rsv),
    .rsv_sending (rsv_on_wire),
    .idle_slope  (idle_slope),
    .send_slope  (send_slope),
    .hi_credit   (hi_credit),
    .lo_credit   (lo_credit),
    .credit      (credit_w)
  );

  assign credit_o = credit_w;

  // R1: a reserved grant is never given against a negative credit
  p_rsv_needs_credit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    grant_rsv |-> (credit_o >= 0));

  // R8: the link is never granted twice at once
  p_no_grant_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    link_busy |-> (!grant_rsv && !grant_be));

  // R10: every grant occupies the link from the next cycle
  p_grant_then_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_rsv || grant_be) |=> link_busy);

  // R2: a reserved frame on the wire never raises the credit
  p_send_no_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_on_wire && byte_tick && $stable(lo_credit)) |=> (credit_o <= $past(credit_o)));
endmodule

// File: tb/cbs_shaper_tb_top.sv
module cbs_shaper_tb_top;
  logic               clk = 1'b0;
  logic               rst_n;
  logic               byte_tick;
  logic               rsv_pending, be_pending;
  logic [11:0]        rsv_len, be_len;
  logic [15:0]        idle_slope, send_slope;
  logic signed [31:0] hi_credit, lo_credit;
  logic               grant_rsv, grant_be, link_busy;
  logic signed [31:0] credit_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  cbs_shaper dut_i (
    .clk(clk), .rst_n(rst_n), .byte_tick(byte_tick),
    .rsv_pending(rsv_pending), .be_pending(be_pending),
    .rsv_len(rsv_len), .be_len(be_len),
    .idle_slope(idle_slope), .send_slope(send_slope),
    .hi_credit(hi_credit), .lo_credit(lo_credit),
    .grant_rsv(grant_rsv), .grant_be(grant_be),
    .link_busy(link_busy), .credit_o(credit_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; byte_tick = 1'b1; rsv_pending = 1'b0; be_pending = 1'b0;
    rsv_len = 12'd1; be_len = 12'd1; idle_slope = 16'd10; send_slope = 16'd30;
    hi_credit = 1000; lo_credit = -1000;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 credit after reset", credit_o, 0);
    chk("R11 busy after reset", int'(link_busy), 0);
  endtask

  // Reserved frame drains credit, then best-effort fills in, then credit recovers.
  task automatic t_drain_and_fill();
    do_reset();
    rsv_pending = 1; be_pending = 1; rsv_len = 12'd4; settle();
    chk("R1 grant_rsv at zero credit", int'(grant_rsv), 1);
    chk("R1 be loses at zero credit", int'(grant_be), 0);
    cyc();
    rsv_pending = 0; be_pending = 0; settle();
    chk("R9 credit held in grant cycle", credit_o, 0);
    chk("R10 grant is a pulse", int'(grant_rsv), 0);
    chk("R10 busy after grant", int'(link_busy), 1);
    for (int i = 1; i <= 4; i++) begin
      cyc();
      chk("R2 credit drains per tick", credit_o, -30 * i);
      chk("R10 busy length", int'(link_busy), (i < 4) ? 1 : 0);
    end
    rsv_pending = 1; be_pending = 1; be_len = 12'd2; settle();
    chk("R3 be granted on negative credit", int'(grant_be), 1);
    chk("R3 rsv blocked on negative credit", int'(grant_rsv), 0);
    cyc();
    be_pending = 0; settle();
    chk("R4 credit rises while blocked", credit_o, -110);
    cyc(); chk("R4 rise behind best-effort", credit_o, -100);
    cyc(); chk("R4 rise behind best-effort", credit_o, -90);
    chk("R10 be frame over", int'(link_busy), 0);
    for (int i = 1; i <= 9; i++) begin
      chk("R3 no rsv grant while negative", int'(grant_rsv), 0);
      cyc();
      chk("R4 idle recovery while pending", credit_o, -90 + 10 * i);
    end
    chk("R1 rsv granted once credit is zero", int'(grant_rsv), 1);
    rsv_pending = 0;
  endtask

  task automatic t_positive_reset();
    do_reset();
    be_pending = 1; be_len = 12'd5; settle();
    chk("R3 be granted with rsv empty", int'(grant_be), 1);
    cyc();
    rsv_pending = 1; settle();
    chk("R5 credit stays zero when empty", credit_o, 0);
    for (int i = 1; i <= 5; i++) begin
      chk("R8 no grant while busy", int'(grant_rsv | grant_be), 0);
      cyc();
      chk("R4 credit builds behind be", credit_o, 10 * i);
    end
    rsv_pending = 0; be_pending = 0;
    cyc();
    chk("R5 positive credit cleared when empty", credit_o, 0);
  endtask

  task automatic t_clamp();
    do_reset();
    hi_credit = 25; lo_credit = -50;
    be_pending = 1; be_len = 12'd5; settle();
    cyc();
    rsv_pending = 1; rsv_len = 12'd3;
    for (int i = 1; i <= 5; i++) begin
      cyc();
      chk("R7 upper clamp", credit_o, (10 * i > 25) ? 25 : 10 * i);
    end
    chk("R1 rsv wins at positive credit", int'(grant_rsv), 1);
    chk("R1 be loses at positive credit", int'(grant_be), 0);
    cyc();
    chk("R9 credit held in grant cycle", credit_o, 25);
    cyc(); chk("R2 drain", credit_o, -5);
    chk("R8 no grant while rsv busy", int'(grant_rsv | grant_be), 0);
    cyc(); chk("R2 drain below zero", credit_o, -35);
    cyc(); chk("R7 lower clamp", credit_o, -50);
    chk("R3 be after rsv frame", int'(grant_be), 1);
    rsv_pending = 0; be_pending = 0;
  endtask

  task automatic t_tick_and_recover();
    do_reset();
    send_slope = 16'd15; idle_slope = 16'd7; rsv_len = 12'd2;
    rsv_pending = 1; settle();
    chk("R1 grant at reset credit", int'(grant_rsv), 1);
    cyc();
    rsv_pending = 0; byte_tick = 0;
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk("R9 credit frozen without tick", credit_o, 0);
      chk("R9 busy frozen without tick", int'(link_busy), 1);
    end
    byte_tick = 1;
    cyc(); chk("R2 drain after ticks resume", credit_o, -15);
    cyc(); chk("R2 drain after ticks resume", credit_o, -30);
    chk("R10 busy ends after length", int'(link_busy), 0);
    cyc(); chk("R6 empty recovery", credit_o, -23);
    cyc(); chk("R6 empty recovery", credit_o, -16);
    cyc(); chk("R6 empty recovery", credit_o, -9);
    cyc(); chk("R6 empty recovery", credit_o, -2);
    cyc(); chk("R6 recovery stops at zero", credit_o, 0);
    cyc(); chk("R6 stays at zero", credit_o, 0);
    be_pending = 1; be_len = 12'd0; settle();
    chk("R10 be grant for zero length", int'(grant_be), 1);
    cyc();
    be_pending = 0; settle();
    chk("R10 zero length busy one tick", int'(link_busy), 1);
    cyc();
    chk("R10 zero length busy ends", int'(link_busy), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_drain_and_fill();
    t_positive_reset();
    t_clamp();
    t_tick_and_recover();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule